// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is the control-register front end of a multi-channel sensor front end. A host reaches it over a three-wire serial bus: an active-low frame enable, a serial clock and one data line that changes direction during a read. Inside the block sit eleven 8-bit control registers. It exports their fields as plain outputs: run/power-down, per-channel sample-and-hold gain, reference selection, channel mode, per-channel offset codes, per-channel digital gains, output control bits and per-LED current codes. The analog and datapath logic that uses these fields lies outside this block.

The three serial lines are oversampled by the faster system clock. Each line passes through a synchronizer, and the clock and enable are edge-detected in the system clock domain. A frame is 16 bits, sent most significant first. The first bit selects the direction. Three reserved bits that must be zero follow it. Then come a 4-bit register address and 8 data bits. A write is committed only when the enable returns high, and only if the whole frame was clocked in. A read turns the data line around once the address is known. It shifts the register out MSB first, followed by zeros.

Because the data line is bidirectional, the block exposes it as a separate input, an output and an output-enable. The pad logic outside the block combines them.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset, every exported field is 0 and the data output enable `serDatOe` is low.
- R2: A write frame has the bit order direction (0 = write), three reserved zeros, address MSB first, then data MSB first. It stores the data, restricted to the register's defined bits, into the addressed register (0x0 to 0xA).
- R3: A complete write frame changes no exported field while the enable is still low. The new value appears only after the enable rises.
- R4: A frame that ends with fewer than 16 rising serial clock edges leaves every register unchanged.
- R5: When more than 16 rising edges arrive in a frame, only the first 16 bits are used and the later bits are ignored.
- R6: A write to an address from 0xB to 0xF is ignored, and so is a frame whose reserved bits are not all zero. No exported field changes.
- R7: In a read frame (first bit 1), `serDatOe` stays low through the eighth rising edge. It goes high at the falling edge that follows, and from that edge `serDatOut` gives the addressed register MSB first, one bit per falling edge.
- R8: A read frame drives 0 on `serDatOut` for every clock after the eighth data bit. `serDatOe` returns low once the enable goes high.
- R9: Undefined register bits read back as 0 and are never stored. A read of address 0xB to 0xF returns 0x00.
- R10: The field layout is as follows. Register 0 bit 7 is the run bit (1 = running), bits 6, 5 and 4 are the sample-and-hold gains of channels 0, 1 and 2, bit 2 selects the internal reference, bit 1 selects the higher internal level and bit 0 selects single-channel mode. Registers 1 to 3 bits 5:0 are the channel offsets. Registers 4 to 6 are the channel digital gains. Register 7 bit 5 is cascade, bit 4 is the device id, bit 2 is reduced drive and bit 0 is Gray output. Registers 8 to 0xA bits 2:0 are the LED currents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bus clock |
| serEnN | input | 1 | Serial frame enable, active low |
| serDatIn | input | 1 | Serial data from the pad |
| serDatOut | output | 1 | Serial read data to the pad |
| serDatOe | output | 1 | Pad output enable for read data |
| runEn | output | 1 | Register 0 bit 7, 1 = running |
| shGain | output | 3 | Sample-and-hold gain per channel, index = channel |
| refInternal | output | 1 | Internal reference selected |
| refHigh | output | 1 | Higher internal reference level |
| singleChan | output | 1 | Single-channel input mode |
| offsetCh | output | 3x6 | Offset code per channel |
| digGainCh | output | 3x8 | Digital gain code per channel |
| cascadeEn | output | 1 | Cascaded output mode |
| devId | output | 1 | Device id for cascaded mode |
| lowDrive | output | 1 | Reduced output drive |
| grayOut | output | 1 | Gray-coded output format |
| ledCur | output | 3x3 | Current code per LED |

## Verification
The assertions check several properties on every cycle. The bit counter never passes 16. The register array holds still except in the cycle after a write strobe. Undefined bits stay zero. The output enable rises only after a serial clock falling edge and is low whenever the enable was high. Field mapping, the commit point at the enable's rising edge, short and long frames, rejected addresses and reserved bits, and the serial bit order of read data are shown only by the bench's frames. The bench rebuilds register values from the field ports and collects read bits at the pads.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  parameter int DATA_W    = 8;
  parameter int ADDR_W    = 4;
  parameter int RSV_W     = 3;
  parameter int REG_COUNT = 11;
  parameter int OFS_W     = 6;
  parameter int LED_W     = 3;
  parameter int CHANS     = 3;

  localparam int HDR_BITS   = 1 + RSV_W + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdLoad;
    logic              rdShift;
    logic [ADDR_W-1:0] rdAddr;
  } ctrl_stb_t;

  // Bits that exist in each register; all others are stored and read as 0.
  function automatic logic [DATA_W-1:0] regMask(input int idx);
    logic [DATA_W-1:0] m;
    if (idx == 0)                      m = 8'hF7;
    else if (idx >= 1 && idx <= 3)     m = 8'h3F;
    else if (idx >= 4 && idx <= 6)     m = 8'hFF;
    else if (idx == 7)                 m = 8'h35;
    else if (idx >= 8 && idx <= 10)    m = 8'h07;
    else                               m = '0;
    return m;
  endfunction
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
  import serreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClk,
  input  logic      serEnN,
  input  logic      serDatIn,
  output ctrl_stb_t stb,
  output logic      datOe
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
  localparam int RW_POS = HDR_BITS - 1;

  logic sclkS, enS, dinS;
  logic sclkD, enD;

  serreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncClk (
    .clk(clk), .rstN(rstN), .din(serClk), .dout(sclkS));
  serreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSyncEn (
    .clk(clk), .rstN(rstN), .din(serEnN), .dout(enS));
  serreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSyncDat (
    .clk(clk), .rstN(rstN), .din(serDatIn), .dout(dinS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      enD   <= 1'b1;
    end else begin
      sclkD <= sclkS;
      enD   <= enS;
    end
  end

  logic sclkRise, sclkFall, enRise;
  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;
  assign enRise   = enS & ~enD;

  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] frame;
  logic [HDR_BITS-1:0]   hdr;

  logic rsvZero, rdPhase;
  assign rsvZero = (hdr[RW_POS-1 -: RSV_W] == '0);
  assign rdPhase = (bitCnt >= HDR_CNT) && hdr[RW_POS] && !enS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      frame  <= '0;
      hdr    <= '0;
      datOe  <= 1'b0;
    end else if (enS) begin
      bitCnt <= '0;
      datOe  <= 1'b0;
    end else begin
      if (sclkRise && bitCnt < FULL_CNT) begin
        frame  <= {frame[FRAME_BITS-2:0], dinS};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == HDR_CNT - 1'b1) hdr <= {frame[HDR_BITS-2:0], dinS};
      end
      if (sclkFall && rdPhase) datOe <= 1'b1;
    end
  end

  always_comb begin
    stb.wrStb   = enRise && (bitCnt == FULL_CNT) && !hdr[RW_POS] && rsvZero;
    stb.wrAddr  = hdr[ADDR_W-1:0];
    stb.wrData  = frame[DATA_W-1:0];
    stb.rdLoad  = sclkFall && rdPhase && !datOe;
    stb.rdShift = sclkFall && rdPhase && datOe;
    stb.rdAddr  = rsvZero ? hdr[ADDR_W-1:0] : '1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT); // R5
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datOe) |-> $past(sclkFall)); // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(enS) |-> !datOe); // R8
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrl_stb_t                         stb,
  output logic [REG_COUNT-1:0][DATA_W-1:0]  regsOut,
  output logic                              datOut
);
  logic [DATA_W-1:0] rdByte;
  logic [DATA_W-1:0] rdSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regsOut <= '0;
    end else if (stb.wrStb) begin
      for (int r = 0; r < REG_COUNT; r++)
        if (stb.wrAddr == ADDR_W'(r)) regsOut[r] <= stb.wrData & regMask(r);
    end
  end

  always_comb begin
    rdByte = '0;
    for (int r = 0; r < REG_COUNT; r++)
      if (stb.rdAddr == ADDR_W'(r)) rdByte = regsOut[r];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdSh <= '0;
    else if (stb.rdLoad)  rdSh <= rdByte;
    else if (stb.rdShift) rdSh <= {rdSh[DATA_W-2:0], 1'b0};
  end

  assign datOut = rdSh[DATA_W-1];

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrStb) |-> $stable(regsOut)); // R3

  for (genvar g = 0; g < REG_COUNT; g++) begin : gUndef
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (regsOut[g] & ~regMask(g)) == '0); // R9
  end
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serClk,
  input  logic                          serEnN,
  input  logic                          serDatIn,
  output logic                          serDatOut,
  output logic                          serDatOe,
  output logic                          runEn,
  output logic [CHANS-1:0]              shGain,
  output logic                          refInternal,
  output logic                          refHigh,
  output logic                          singleChan,
  output logic [CHANS-1:0][OFS_W-1:0]   offsetCh,
  output logic [CHANS-1:0][DATA_W-1:0]  digGainCh,
  output logic                          cascadeEn,
  output logic                          devId,
  output logic                          lowDrive,
  output logic                          grayOut,
  output logic [CHANS-1:0][LED_W-1:0]   ledCur
);
  ctrl_stb_t                        stb;
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;

  serreg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serEnN(serEnN),
    .serDatIn(serDatIn), .stb(stb), .datOe(serDatOe));

  serreg_bank uBank (
    .clk(clk), .rstN(rstN), .stb(stb), .regsOut(regs), .datOut(serDatOut));

  assign runEn       = regs[0][7];
  assign refInternal = regs[0][2];
  assign refHigh     = regs[0][1];
  assign singleChan  = regs[0][0];
  assign cascadeEn   = regs[7][5];
  assign devId       = regs[7][4];
  assign lowDrive    = regs[7][2];
  assign grayOut     = regs[7][0];

  for (genvar c = 0; c < CHANS; c++) begin : gChan
    assign shGain[c]    = regs[0][6-c];
    assign offsetCh[c]  = regs[1+c][OFS_W-1:0];
    assign digGainCh[c] = regs[4+c];
    assign ledCur[c]    = regs[8+c][LED_W-1:0];
  end
endmodule

// File: tb/sim_serial_ctl_regs.sv
module sim_serial_ctl_regs;
  logic clk = 0, rstN = 0;
  logic serClk = 0, serEnN = 1, serDatIn = 0;
  logic serDatOut, serDatOe;
  logic runEn, refInternal, refHigh, singleChan, cascadeEn, devId, lowDrive, grayOut;
  logic [2:0] shGain;
  logic [2:0][5:0] offsetCh;
  logic [2:0][7:0] digGainCh;
  logic [2:0][2:0] ledCur;

  serial_ctl_regs u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl [11];
  logic [7:0] expQ [$];
  logic [7:0] actQ [$];
  string      tagQ [$];

  function automatic logic [7:0] maskOf(input int a);
    if (a == 0) return 8'hF7;
    if (a <= 3) return 8'h3F;
    if (a <= 6) return 8'hFF;
    if (a == 7) return 8'h35;
    if (a <= 10) return 8'h07;
    return 8'h00;
  endfunction

  function automatic logic [7:0] portVal(input int a);
    case (a)
      0: return {runEn, shGain[0], shGain[1], shGain[2], 1'b0, refInternal, refHigh, singleChan};
      1, 2, 3: return {2'b00, offsetCh[a-1]};
      4, 5, 6: return digGainCh[a-4];
      7: return {2'b00, cascadeEn, devId, 1'b0, lowDrive, 1'b0, grayOut};
      8, 9, 10: return {5'b0, ledCur[a-8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a <= 10; a++) check(tag, portVal(a), mdl[a]);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Drives one frame of nClk serial clocks. A read frame releases the data
  // line after the header and samples the returned bits at the pads.
  task automatic frame(input logic [15:0] bits, input int nClk, input bit isRead,
                       input bit holdChk, input int holdAddr);
    logic [7:0] got = '0;
    serEnN = 0;
    waitClk(4);
    for (int i = 0; i < nClk; i++) begin
      serClk = 0;
      serDatIn = (i < 16 && !(isRead && i >= 8)) ? bits[15-i] : 1'b1;
      if (isRead && i >= 8) serDatIn = 1'b0;
      waitClk(6);
      if (isRead && i == 7) check("R7 oe low before turnaround", {7'b0, serDatOe}, 8'h00);
      if (isRead && i >= 8 && i < 16) begin
        got[15-i] = serDatOut;
        if (i == 8) check("R7 oe high after turnaround", {7'b0, serDatOe}, 8'h01);
      end
      if (isRead && i >= 16) check("R8 zero padding", {6'b0, serDatOe, serDatOut}, 8'h02);
      serClk = 1;
      waitClk(6);
    end
    serClk = 0;
    waitClk(6);
    if (holdChk) check("R3 no commit before enable rise", portVal(holdAddr), mdl[holdAddr]);
    serEnN = 1;
    waitClk(8);
    if (isRead) begin
      check("R8 oe released", {7'b0, serDatOe}, 8'h00);
      actQ.push_back(got);
    end
  endtask

  task automatic doWrite(input int a, input logic [7:0] d, input string tag);
    frame({1'b0, 3'b000, a[3:0], d}, 16, 0, 1, a);
    if (a <= 10) mdl[a] = d & maskOf(a);
    checkAll(tag);
  endtask

  task automatic doRead(input int a, input int nClk, input string tag);
    expQ.push_back(a <= 10 ? mdl[a] : 8'h00);
    tagQ.push_back(tag);
    frame({1'b1, 3'b000, a[3:0], 8'h00}, nClk, 1, 0, 0);
  endtask

  // Scoreboard monitor: pairs each captured read byte with its expectation.
  initial begin
    forever begin
      wait (actQ.size() > 0);
      check(tagQ.pop_front(), actQ.pop_front(), expQ.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a <= 10; a++) mdl[a] = 8'h00;
    waitClk(5);
    rstN = 1;
    waitClk(3);
    checkAll("R1 reset fields");
    check("R1 reset oe", {7'b0, serDatOe}, 8'h00);

    doWrite(0, 8'hFF, "R2 R10 reg0 fields");
    doWrite(0, 8'hA5, "R10 reg0 pattern");
    doWrite(1, 8'h2A, "R2 R10 offset ch0");
    doWrite(3, 8'hFF, "R9 offset undefined bits");
    doWrite(4, 8'hC3, "R2 R10 gain ch0");
    doWrite(6, 8'h3C, "R10 gain ch2");
    doWrite(7, 8'hFF, "R9 R10 reg7 defined bits");
    doWrite(8, 8'hFD, "R9 R10 led r");
    doWrite(10, 8'h06, "R10 led b");

    // Short frame: 15 clocks.
    frame({1'b0, 3'b000, 4'h4, 8'h11}, 15, 0, 0, 0);
    checkAll("R4 short frame ignored");

    // Long frame: extra bits after 16 are ones.
    frame({1'b0, 3'b000, 4'h5, 8'h5A}, 21, 0, 0, 0);
    mdl[5] = 8'h5A;
    checkAll("R5 long frame first 16 bits");

    frame({1'b0, 3'b000, 4'hB, 8'hFF}, 16, 0, 0, 0);
    checkAll("R6 inhibited address write");
    frame({1'b0, 3'b010, 4'h1, 8'h15}, 16, 0, 0, 0);
    checkAll("R6 reserved bits nonzero");

    doRead(0, 16, "R7 read reg0");
    doRead(4, 16, "R7 read gain ch0");
    doRead(7, 16, "R9 read reg7 undefined zero");
    doRead(12, 16, "R9 read inhibited address");
    doRead(8, 20, "R8 read with extra clocks");
    waitClk(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule